// File: doc/BRIEF.md
# Polynomial Sensor Compensation Datapath

This block turns a raw signed sensor sample into a temperature-compensated reading. Seven signed 16-bit calibration coefficients sit in a small register file. The register file is loaded through a simple write port and can be inspected through a read port. When a start pulse arrives, the block captures the signal sample and the temperature sample. It then evaluates a fixed two-factor equation:

dout = Gain·(1 + G1·T + G2·T²)·(S + Of0 + Of1·T + Of2·T²) + Doff

All values are Q1.15 fractions. One shared multiplier is stepped by a small sequencer, and a one-cycle done pulse marks the moment the new result is on `dout_o`.

A conversion reads the coefficients straight from the register file. Software can therefore write new values and start the next conversion with no separate load step. Reset clears every coefficient to zero.

Top module: `sc_comp_top`

## Requirements
- R1: While `rst_ni` is low and after it is released, all coefficient registers read zero, and `busy_o`, `done_o` and `dout_o` are zero.
- R2: A write with `wr_en_i` high stores `wr_data_i` at `wr_addr_i`. The addresses are: 0 Gain, 1 G1, 2 G2, 3 Of0, 4 Of1, 5 Of2, 6 Doff. `rd_data_o` shows the register selected by `rd_addr_i` combinationally.
- R3: Address 7 holds nothing. A write to it changes no register, and a read of it returns 0.
- R4: The result uses the following arithmetic:
  - Each product is `floor(a·b / 2^15)` of its signed operands.
  - The terms are t2 = T·T, g = 32768 + G1·T + G2·t2, s = S + Of0 + Of1·T + Of2·t2 and gg = Gain·g.
  - The pre-saturation result is gg·s + Doff.
  - Intermediate sums are wide enough that they never wrap.
- R5: The final result saturates to the range -32768..32767 instead of wrapping.
- R6: A start accepted at a clock edge sets `busy_o` high. `done_o` is high for exactly one cycle, 7 clock edges after the start edge. `busy_o` falls at that same edge, and `dout_o` updates at that same edge.
- R7: `start_i` while `busy_o` is high is ignored. It causes no restart, no extra done pulse and no change to the result.
- R8: `sig_i` and `temp_i` are captured at the start edge. Changes to them during a conversion have no effect on the result.
- R9: `dout_o` holds its value between conversions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Coefficient write strobe |
| wr_addr_i | input | 3 | Coefficient write address |
| wr_data_i | input | 16 | Coefficient write data, two's complement |
| rd_addr_i | input | 3 | Coefficient read address |
| rd_data_o | output | 16 | Coefficient read data |
| start_i | input | 1 | Conversion start request |
| sig_i | input | 16 | Signed signal sample, Q1.15 |
| temp_i | input | 16 | Signed temperature sample, Q1.15 |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle pulse when the result is valid |
| dout_o | output | 16 | Compensated, saturated result |

## Verification
The equation is exercised in four ways:
- **All-zero coefficients** show that reset leaves a neutral datapath.
- **Full-range random coefficients and samples** cover the floor rounding of every product and the carries of the wide sums.
- **Extreme positive and negative operands** force both saturation rails, which separates clamping from wrap-around.
- **Changing the samples and pulsing start during a conversion** shows whether inputs are captured at the start edge and whether a busy start is dropped.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int unsigned NCOEF = 7;

  typedef enum logic [2:0] {
    C_GAIN = 3'd0,
    C_G1   = 3'd1,
    C_G2   = 3'd2,
    C_OF0  = 3'd3,
    C_OF1  = 3'd4,
    C_OF2  = 3'd5,
    C_DOFF = 3'd6
  } coef_idx_e;
endpackage

// File: rtl/sc_coef_rf.sv
module sc_coef_rf #(
  parameter int unsigned CW    = 16,
  parameter int unsigned NCOEF = 7,
  parameter int unsigned AW    = 3
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic [AW-1:0]              wr_addr_i,
  input  logic [CW-1:0]              wr_data_i,
  input  logic [AW-1:0]              rd_addr_i,
  output logic [CW-1:0]              rd_data_o,
  output logic [NCOEF-1:0][CW-1:0]   coef_o
);
  for (genvar i = 0; i < NCOEF; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                      coef_o[i] <= '0;
      else if (wr_en_i && wr_addr_i == AW'(i))          coef_o[i] <= wr_data_i;
    end
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NCOEF; i++)
      if (rd_addr_i == AW'(i)) rd_data_o = coef_o[i];
  end
endmodule

// File: rtl/sc_mul.sv
module sc_mul #(
  parameter int unsigned AW   = 24,
  parameter int unsigned FRAC = 15
) (
  input  logic signed [AW-1:0] a_i,
  input  logic signed [AW-1:0] b_i,
  output logic signed [AW-1:0] p_o
);
  logic signed [2*AW-1:0] full;
  logic signed [2*AW-1:0] shr;

  assign full = a_i * b_i;
  assign shr  = full >>> FRAC;      // floor rescale
  assign p_o  = shr[AW-1:0];        // magnitudes bounded well below 2^(AW-1)
endmodule

// File: rtl/sc_seq.sv
module sc_seq
  import sc_pkg::*;
#(
  parameter int unsigned CW    = 16,
  parameter int unsigned ACC_W = 24,
  parameter int unsigned FRAC  = 15,
  parameter int unsigned NC    = 7
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic [CW-1:0]            sig_i,
  input  logic [CW-1:0]            temp_i,
  input  logic [NC-1:0][CW-1:0]    coef_i,
  output logic signed [ACC_W-1:0]  mul_a_o,
  output logic signed [ACC_W-1:0]  mul_b_o,
  input  logic signed [ACC_W-1:0]  mul_p_i,
  output logic                     busy_o,
  output logic                     done_o,
  output logic [CW-1:0]            dout_o
);
  localparam int unsigned LAST = 6;
  localparam logic signed [ACC_W-1:0] ONE  = ACC_W'(1) <<< FRAC;
  localparam logic signed [ACC_W-1:0] PMAX = ACC_W'((1 << (CW-1)) - 1);
  localparam logic signed [ACC_W-1:0] PMIN = -(ACC_W'(1) <<< (CW-1));

  function automatic logic signed [ACC_W-1:0] sx(input logic [CW-1:0] v);
    return {{(ACC_W-CW){v[CW-1]}}, v};
  endfunction

  logic [2:0]              step_q;
  logic signed [ACC_W-1:0] s_q, t_q, t2_q, gacc_q, sacc_q, gg_q;
  logic signed [ACC_W-1:0] fin;
  logic [CW-1:0]           fin_sat;

  always_comb begin
    mul_a_o = '0;
    mul_b_o = '0;
    unique case (step_q)
      3'd0:    begin mul_a_o = t_q;               mul_b_o = t_q;    end
      3'd1:    begin mul_a_o = sx(coef_i[C_G1]);  mul_b_o = t_q;    end
      3'd2:    begin mul_a_o = sx(coef_i[C_G2]);  mul_b_o = t2_q;   end
      3'd3:    begin mul_a_o = sx(coef_i[C_OF1]); mul_b_o = t_q;    end
      3'd4:    begin mul_a_o = sx(coef_i[C_OF2]); mul_b_o = t2_q;   end
      3'd5:    begin mul_a_o = sx(coef_i[C_GAIN]);mul_b_o = gacc_q; end
      default: begin mul_a_o = gg_q;              mul_b_o = sacc_q; end
    endcase
  end

  assign fin = mul_p_i + sx(coef_i[C_DOFF]);

  always_comb begin
    if (fin > PMAX)      fin_sat = PMAX[CW-1:0];
    else if (fin < PMIN) fin_sat = PMIN[CW-1:0];
    else                 fin_sat = fin[CW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= '0;
      busy_o <= 1'b0;
      done_o <= 1'b0;
      dout_o <= '0;
      s_q    <= '0;
      t_q    <= '0;
      t2_q   <= '0;
      gacc_q <= '0;
      sacc_q <= '0;
      gg_q   <= '0;
    end else begin
      done_o <= 1'b0;
      if (!busy_o) begin
        if (start_i) begin
          busy_o <= 1'b1;
          step_q <= '0;
          s_q    <= sx(sig_i);
          t_q    <= sx(temp_i);
        end
      end else begin
        unique case (step_q)
          3'd0: t2_q   <= mul_p_i;
          3'd1: gacc_q <= ONE + mul_p_i;
          3'd2: gacc_q <= gacc_q + mul_p_i;
          3'd3: sacc_q <= s_q + sx(coef_i[C_OF0]) + mul_p_i;
          3'd4: sacc_q <= sacc_q + mul_p_i;
          3'd5: gg_q   <= mul_p_i;
          default: begin
            dout_o <= fin_sat;
            done_o <= 1'b1;
            busy_o <= 1'b0;
          end
        endcase
        if (step_q != 3'(LAST)) step_q <= step_q + 3'd1;
      end
    end
  end
endmodule

// File: rtl/sc_comp_top.sv
module sc_comp_top #(
  parameter int unsigned CW    = 16,
  parameter int unsigned AW    = 3,
  parameter int unsigned ACC_W = 24,
  parameter int unsigned FRAC  = 15
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [CW-1:0] wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [CW-1:0] rd_data_o,
  input  logic          start_i,
  input  logic [CW-1:0] sig_i,
  input  logic [CW-1:0] temp_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [CW-1:0] dout_o
);
  localparam int unsigned NC = sc_pkg::NCOEF;

  logic [NC-1:0][CW-1:0]   coef;
  logic signed [ACC_W-1:0] mul_a, mul_b, mul_p;

  sc_coef_rf #(.CW(CW), .NCOEF(NC), .AW(AW)) u_rf (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .rd_addr_i, .rd_data_o, .coef_o(coef)
  );

  sc_mul #(.AW(ACC_W), .FRAC(FRAC)) u_mul (
    .a_i(mul_a), .b_i(mul_b), .p_o(mul_p)
  );

  sc_seq #(.CW(CW), .ACC_W(ACC_W), .FRAC(FRAC), .NC(NC)) u_seq (
    .clk_i, .rst_ni, .start_i, .sig_i, .temp_i, .coef_i(coef),
    .mul_a_o(mul_a), .mul_b_o(mul_b), .mul_p_i(mul_p),
    .busy_o, .done_o, .dout_o
  );
endmodule

// File: rtl/sc_chk.sv
module sc_chk #(
  parameter int unsigned CW = 16,
  parameter int unsigned AW = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_en_i,
  input logic [AW-1:0] wr_addr_i,
  input logic [CW-1:0] wr_data_i,
  input logic [AW-1:0] rd_addr_i,
  input logic [CW-1:0] rd_data_o,
  input logic          start_i,
  input logic [CW-1:0] sig_i,
  input logic [CW-1:0] temp_i,
  input logic          busy_o,
  input logic          done_o,
  input logic [CW-1:0] dout_o
);
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R6
  AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o); // R6
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o); // R6
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R7
  AST_DOUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> $stable(dout_o)); // R9
  AST_NO_SLOT7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_addr_i == AW'(7)) |-> (rd_data_o == '0)); // R3
  AST_RST_IDLE: assert property (@(posedge clk_i)
    !rst_ni |-> (!busy_o && !done_o && dout_o == '0)); // R1
endmodule

bind sc_comp_top sc_chk #(.CW(CW), .AW(AW)) u_chk (.*);

// File: tb/tb_sc_comp_top.sv
`timescale 1ns/1ps
module tb_sc_comp_top;
  logic        clk = 0, rst_ni = 0;
  logic        wr_en_i = 0, start_i = 0;
  logic [2:0]  wr_addr_i = 0, rd_addr_i = 0;
  logic [15:0] wr_data_i = 0, sig_i = 0, temp_i = 0;
  logic [15:0] rd_data_o, dout_o;
  logic        busy_o, done_o;
  int          n_chk = 0, n_fail = 0;
  int          c [7];

  always #2.5 clk = ~clk;

  sc_comp_top dut (.clk_i(clk), .*);

  task automatic check(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint mq(longint a, longint b);
    return (a * b) >>> 15;
  endfunction

  function automatic longint model(int s, int t);
    longint t2, g, sf, gg, r;
    t2 = mq(t, t);
    g  = 32768 + mq(c[1], t) + mq(c[2], t2);
    sf = s + c[3] + mq(c[4], t) + mq(c[5], t2);
    gg = mq(c[0], g);
    r  = mq(gg, sf) + c[6];
    if (r > 32767)  r = 32767;
    if (r < -32768) r = -32768;
    return r;
  endfunction

  task automatic wr(int a, int v);
    @(negedge clk);
    wr_en_i = 1; wr_addr_i = a[2:0]; wr_data_i = v[15:0];
    @(negedge clk);
    wr_en_i = 0;
  endtask

  task automatic load(int g, int g1, int g2, int o0, int o1, int o2, int d);
    c = '{g, g1, g2, o0, o1, o2, d};
    for (int i = 0; i < 7; i++) wr(i, c[i]);
  endtask

  // disturb: change samples and pulse start mid-conversion (R7, R8)
  task automatic convert(string req, int s, int t, bit disturb);
    longint exp;
    int k;
    exp = model(s, t);
    @(negedge clk);
    start_i = 1; sig_i = s[15:0]; temp_i = t[15:0];
    @(negedge clk);
    start_i = 0;
    k = 0;
    while (!done_o && k < 40) begin
      @(negedge clk);
      k++;
      if (disturb && k == 1) begin sig_i = ~sig_i; temp_i = temp_i ^ 16'h5a5a; end
      if (disturb && k == 2) start_i = 1;
      if (disturb && k == 3) start_i = 0;
    end
    check({req, " R6 latency"}, k, 7);
    check({req, " R4 result"}, longint'($signed(dout_o)), exp);
    @(negedge clk);
    check({req, " R6/R7 single done"}, {busy_o, done_o}, 0);
    check({req, " R9 hold"}, longint'($signed(dout_o)), exp);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1 reset busy/done/dout", {busy_o, done_o, dout_o}, 0);
    rst_ni = 1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); rd_addr_i = i[2:0]; #1;
      check("R1 coef clear", rd_data_o, 0);
    end
    c = '{0, 0, 0, 0, 0, 0, 0};
    convert("R1 zero coefs", 12345, -777, 0);

    load(16'h1234, -5, 300, 16'h7000, -32768, 12, -9);
    for (int i = 0; i < 7; i++) begin
      @(negedge clk); rd_addr_i = i[2:0]; #1;
      check("R2 readback", rd_data_o, c[i] & 16'hffff);
    end
    wr(7, 16'hbeef);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); rd_addr_i = i[2:0]; #1;
      check("R3 slot7 ignored", rd_data_o, (i == 7) ? 0 : (c[i] & 16'hffff));
    end

    load(16384, 0, 0, 0, 0, 0, 0);
    convert("R4 half gain", 20000, 0, 0);
    load(32767, 32767, 32767, 32767, 32767, 32767, 32767);
    convert("R5 positive rail", 32767, 32767, 0);
    load(32767, 0, 0, -32768, 0, 0, -32768);
    convert("R5 negative rail", -32768, 0, 0);
    load(-32768, -32768, 1, -1, -32768, -32768, 0);
    convert("R4 min temp", -32768, -32768, 0);
    load(20000, -3000, 1500, 400, -800, 250, -100);
    convert("R8 disturbed", 9000, -12000, 1);
    convert("R7 disturbed", -15000, 22000, 1);

    for (int n = 0; n < 40; n++) begin
      load($signed(16'($urandom)), $signed(16'($urandom)), $signed(16'($urandom)),
           $signed(16'($urandom)), $signed(16'($urandom)), $signed(16'($urandom)),
           $signed(16'($urandom)));
      convert("R4 random", $signed(16'($urandom)), $signed(16'($urandom)), n[0]);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule